// File: doc/BRIEF.md
# Parallel SCSI Port Register Interface

This block is the host-side register file of a parallel SCSI bus port. A host reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. Writes load the control state: the byte to place on the data lines, the initiator control lines, the operating mode, the target phase lines and a mask of selection IDs. Reads return live copies of the bus lines, the latched input byte and a combined bus-and-condition byte. At several offsets a read and a write reach different registers.

The block drives the open-collector bus outputs as active-high assert requests. It compares the bus phase lines with the programmed target phase, and it latches incoming bytes on the trailing edge of the handshake. It keeps sticky flags for parity and busy errors and raises an interrupt on selection, bad parity, loss of BSY or end of DMA. Writes to the three upper offsets only issue one-cycle DMA start strobes. Arbitration timing and data movement are handled elsewhere.

Top module: `scsi_port_regs`

## Requirements
- R1: After reset every writable register is zero, no bus output is asserted, `bus_data_oe` and `irq_o` are low, and offsets 1, 2 and 3 read zero.
- R2: Offset 0 reads `bus_data_i`. Offset 4 reads {RST, BSY, REQ, MSG, C/D, I/O, SEL, parity} from bit 7 down to bit 0. Offset 2 reads back the mode byte. Offset 1 reads {ICR[7], MODE[0], lost, ICR[4:0]}, where lost = MODE[0] & SEL & ~ICR[2]. Offset 3 reads {dma_end_i, 000, TCR[3:0]}.
- R3: `phase_match_o` is 1 exactly when {MSG, C/D, I/O} on the bus equals TCR[2:0], so data out = 000, data in = 001, command = 010, status = 011, message out = 110 and message in = 111. Offset 5 reads {dma_end_i, drq_i, parity error, irq, phase match, busy error, ATN, ACK}.
- R4: `bus_data_o` always carries the output data register. `bus_data_oe` = ~ICR[6] & (MODE[0] | (ICR[0] & phase match)).
- R5: Control outputs follow the ICR bits: RST bit 7, ACK bit 4, BSY bit 3, SEL bit 2, ATN bit 1. REQ, MSG, C/D and I/O follow TCR[3:0] only while MODE[6] (target) is set. ICR[6] (tri-state) forces every bus output low. `diff_en_o` follows ICR[5].
- R6: A write to offset 5, 6 or 7 pulses, during the write cycle only, the DMA send, target receive or initiator receive strobe respectively, and it leaves every register unchanged.
- R7: When BSY is low, SEL is high and a data line is high whose bit is set in the select-enable register (written at offset 4), the interrupt is set on the next clock.
- R8: On a falling edge of REQ (MODE[6]=0) or of ACK (MODE[6]=1), the input byte read at offset 6 captures `bus_data_i`.
- R9: At each such capture, if MODE[5] is set and the data bits together with the parity bit hold an even number of ones, the sticky parity error is set. MODE[4] also sets the interrupt.
- R10: With MODE[2] set, a falling edge of BSY sets the sticky busy error and the interrupt.
- R11: A read of offset 7 clears the interrupt, the parity error and the busy error. If a new condition arrives in the same cycle, it takes priority.
- R12: With MODE[3] set, a rising edge of `dma_end_i` sets the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| bus_data_i | input | DW | Data lines as seen on the bus |
| bus_par_i | input | 1 | Data parity line |
| bus_rst_i | input | 1 | RST line |
| bus_bsy_i | input | 1 | BSY line |
| bus_sel_i | input | 1 | SEL line |
| bus_req_i | input | 1 | REQ line |
| bus_ack_i | input | 1 | ACK line |
| bus_msg_i | input | 1 | MSG line |
| bus_cd_i | input | 1 | C/D line |
| bus_io_i | input | 1 | I/O line |
| bus_atn_i | input | 1 | ATN line |
| drq_i | input | 1 | DMA request mirror |
| dma_end_i | input | 1 | End of DMA indication |
| bus_data_o | output | DW | Data to drive |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rst_o | output | 1 | Assert RST |
| bus_bsy_o | output | 1 | Assert BSY |
| bus_sel_o | output | 1 | Assert SEL |
| bus_atn_o | output | 1 | Assert ATN |
| bus_ack_o | output | 1 | Assert ACK |
| bus_req_o | output | 1 | Assert REQ |
| bus_msg_o | output | 1 | Assert MSG |
| bus_cd_o | output | 1 | Assert C/D |
| bus_io_o | output | 1 | Assert I/O |
| diff_en_o | output | 1 | Differential driver enable |
| phase_match_o | output | 1 | Bus phase equals target phase |
| irq_o | output | 1 | Interrupt |
| dma_send_go | output | 1 | DMA send start strobe |
| dma_trecv_go | output | 1 | Target DMA receive start strobe |
| dma_irecv_go | output | 1 | Initiator DMA receive start strobe |

## Verification
Random register writes and random bus line values test the compound data-enable condition and the tri-state override at the same time. A design that enabled the data drivers on assert-DATA alone, or let tri-state through, would drive the bus outside a matched phase. Directed cases test parity at the boundary between an even and an odd count of ones, a selection whose ID is masked off, and a BSY drop with monitoring disabled. Each of these would expose an inverted parity sense or an unmasked interrupt. Clears through offset 7 and strobe writes that must leave the registers alone expose decoders that mix up the read and write meanings of an offset.

// File: rtl/scsi_port_pkg.sv
`timescale 1ns/1ps
package scsi_port_pkg;
   localparam int REG_AW = 3;
   localparam int REG_W  = 8;

   typedef enum logic [REG_AW-1:0] {
      OFS_DATA = 3'd0,
      OFS_ICR  = 3'd1,
      OFS_MODE = 3'd2,
      OFS_TCR  = 3'd3,
      OFS_STAT = 3'd4,
      OFS_BSR  = 3'd5,
      OFS_IN   = 3'd6,
      OFS_CLR  = 3'd7
   } ofs_e;

   // initiator command bit positions
   localparam int ICR_RST  = 7;
   localparam int ICR_TRI  = 6;
   localparam int ICR_DIFF = 5;
   localparam int ICR_ACK  = 4;
   localparam int ICR_BSY  = 3;
   localparam int ICR_SEL  = 2;
   localparam int ICR_ATN  = 1;
   localparam int ICR_DATA = 0;

   // mode bit positions
   localparam int MD_TGT   = 6;
   localparam int MD_PCHK  = 5;
   localparam int MD_PINT  = 4;
   localparam int MD_EOPI  = 3;
   localparam int MD_MBSY  = 2;
   localparam int MD_ARB   = 0;

   localparam int TCR_W = 4;
   localparam int N_GO  = 3;
endpackage

// File: rtl/scsi_reg_bank.sv
`timescale 1ns/1ps
module scsi_reg_bank
   import scsi_port_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [REG_AW-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   output logic [DW-1:0]        odr,
   output logic [REG_W-1:0]     icr,
   output logic [REG_W-1:0]     mode,
   output logic [TCR_W-1:0]     tcr,
   output logic [DW-1:0]        selen,
   output logic [N_GO-1:0]      go
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odr   <= '0;
         icr   <= '0;
         mode  <= '0;
         tcr   <= '0;
         selen <= '0;
      end else if (wr) begin
         case (addr)
            OFS_DATA: odr   <= wdata[DW-1:0];
            OFS_ICR:  icr   <= wdata;
            OFS_MODE: mode  <= wdata;
            OFS_TCR:  tcr   <= wdata[TCR_W-1:0];
            OFS_STAT: selen <= wdata[DW-1:0];
            default:  ;
         endcase
      end
   end

   // strobes for offsets 5, 6, 7 in order
   for (genvar g = 0; g < N_GO; g++) begin : g_go
      localparam logic [REG_AW-1:0] GO_OFS = REG_AW'(int'(OFS_BSR) + g);
      assign go[g] = wr && (addr == GO_OFS);
   end

   // R6
   strobe_regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr >= OFS_BSR) |=> ($stable(icr) && $stable(mode) && $stable(tcr)
                                   && $stable(odr) && $stable(selen)));
   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(go));
endmodule

// File: rtl/scsi_bus_drive.sv
`timescale 1ns/1ps
module scsi_bus_drive
   import scsi_port_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [REG_W-1:0]  icr,
   input  logic              tgt_mode,
   input  logic              arb,
   input  logic [TCR_W-1:0]  tcr,
   input  logic [DW-1:0]     odr,
   input  logic [2:0]        bus_phase,
   output logic [DW-1:0]     data_o,
   output logic              data_oe,
   output logic              rst_o,
   output logic              bsy_o,
   output logic              sel_o,
   output logic              atn_o,
   output logic              ack_o,
   output logic              req_o,
   output logic              msg_o,
   output logic              cd_o,
   output logic              io_o,
   output logic              diff_o,
   output logic              pmatch
);
   logic quiet;
   logic tgt_en;

   assign quiet   = icr[ICR_TRI];
   assign tgt_en  = tgt_mode && !quiet;
   assign pmatch  = (bus_phase == tcr[2:0]);
   assign data_o  = odr;
   assign data_oe = !quiet && (arb || (icr[ICR_DATA] && pmatch));
   assign rst_o   = !quiet && icr[ICR_RST];
   assign bsy_o   = !quiet && icr[ICR_BSY];
   assign sel_o   = !quiet && icr[ICR_SEL];
   assign atn_o   = !quiet && icr[ICR_ATN];
   assign ack_o   = !quiet && icr[ICR_ACK];
   assign req_o   = tgt_en && tcr[3];
   assign msg_o   = tgt_en && tcr[2];
   assign cd_o    = tgt_en && tcr[1];
   assign io_o    = tgt_en && tcr[0];
   assign diff_o  = icr[ICR_DIFF];
endmodule

// File: rtl/scsi_event_unit.sv
`timescale 1ns/1ps
module scsi_event_unit
   import scsi_port_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_mode,
   input  logic              par_chk_en,
   input  logic              par_int_en,
   input  logic              eop_int_en,
   input  logic              mon_bsy,
   input  logic [DW-1:0]     selen,
   input  logic [DW-1:0]     bus_data,
   input  logic              bus_par,
   input  logic              bus_bsy,
   input  logic              bus_sel,
   input  logic              bus_req,
   input  logic              bus_ack,
   input  logic              dma_end,
   input  logic              clr,
   output logic              irq,
   output logic              par_err,
   output logic              busy_err,
   output logic [DW-1:0]     in_data
);
   logic prev_bsy, prev_hs, prev_end;
   logic hs, latch_ev, par_ok;
   logic sel_set, par_set, busy_set, eop_set, irq_set;

   assign hs = tgt_mode ? bus_ack : bus_req;
   assign latch_ev = prev_hs && !hs;

   if (ODD_PARITY) begin : g_odd
      assign par_ok = ^{bus_data, bus_par};
   end else begin : g_even
      assign par_ok = ~^{bus_data, bus_par};
   end

   assign sel_set  = !bus_bsy && bus_sel && |(bus_data & selen);
   assign par_set  = latch_ev && par_chk_en && !par_ok;
   assign busy_set = mon_bsy && prev_bsy && !bus_bsy;
   assign eop_set  = eop_int_en && dma_end && !prev_end;
   assign irq_set  = sel_set || (par_set && par_int_en) || busy_set || eop_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bsy <= 1'b0;
         prev_hs  <= 1'b0;
         prev_end <= 1'b0;
         irq      <= 1'b0;
         par_err  <= 1'b0;
         busy_err <= 1'b0;
         in_data  <= '0;
      end else begin
         prev_bsy <= bus_bsy;
         prev_hs  <= hs;
         prev_end <= dma_end;
         irq      <= (irq && !clr) || irq_set;
         par_err  <= (par_err && !clr) || par_set;
         busy_err <= (busy_err && !clr) || busy_set;
         if (latch_ev) in_data <= bus_data;
      end
   end

   // R9
   par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !clr) |=> par_err);
   // R7
   sel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_set |=> irq);
   // R11
   busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !mon_bsy) |=> !busy_err);
   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !irq_set) |=> !irq);
endmodule

// File: rtl/scsi_port_regs.sv
`timescale 1ns/1ps
module scsi_port_regs
   import scsi_port_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [DW-1:0]     bus_data_i,
   input  logic              bus_par_i,
   input  logic              bus_rst_i,
   input  logic              bus_bsy_i,
   input  logic              bus_sel_i,
   input  logic              bus_req_i,
   input  logic              bus_ack_i,
   input  logic              bus_msg_i,
   input  logic              bus_cd_i,
   input  logic              bus_io_i,
   input  logic              bus_atn_i,
   input  logic              drq_i,
   input  logic              dma_end_i,
   output logic [DW-1:0]     bus_data_o,
   output logic              bus_data_oe,
   output logic              bus_rst_o,
   output logic              bus_bsy_o,
   output logic              bus_sel_o,
   output logic              bus_atn_o,
   output logic              bus_ack_o,
   output logic              bus_req_o,
   output logic              bus_msg_o,
   output logic              bus_cd_o,
   output logic              bus_io_o,
   output logic              diff_en_o,
   output logic              phase_match_o,
   output logic              irq_o,
   output logic              dma_send_go,
   output logic              dma_trecv_go,
   output logic              dma_irecv_go
);
   if (DW != REG_W) begin : g_bad_width
      $error("scsi_port_regs: DW must equal the register width");
   end

   logic [DW-1:0]    odr, selen, in_data;
   logic [REG_W-1:0] icr, mode;
   logic [TCR_W-1:0] tcr;
   logic [N_GO-1:0]  go;
   logic             clr, par_err, busy_err, arb_lost;

   scsi_reg_bank #(.DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .odr(odr), .icr(icr), .mode(mode), .tcr(tcr), .selen(selen), .go(go)
   );

   scsi_bus_drive #(.DW(DW)) u_drive (
      .icr(icr), .tgt_mode(mode[MD_TGT]), .arb(mode[MD_ARB]), .tcr(tcr), .odr(odr),
      .bus_phase({bus_msg_i, bus_cd_i, bus_io_i}),
      .data_o(bus_data_o), .data_oe(bus_data_oe), .rst_o(bus_rst_o),
      .bsy_o(bus_bsy_o), .sel_o(bus_sel_o), .atn_o(bus_atn_o), .ack_o(bus_ack_o),
      .req_o(bus_req_o), .msg_o(bus_msg_o), .cd_o(bus_cd_o), .io_o(bus_io_o),
      .diff_o(diff_en_o), .pmatch(phase_match_o)
   );

   assign clr = reg_rd && (reg_addr == OFS_CLR);

   scsi_event_unit #(.DW(DW), .ODD_PARITY(ODD_PARITY)) u_evt (
      .clk(clk), .rst_n(rst_n), .tgt_mode(mode[MD_TGT]),
      .par_chk_en(mode[MD_PCHK]), .par_int_en(mode[MD_PINT]),
      .eop_int_en(mode[MD_EOPI]), .mon_bsy(mode[MD_MBSY]),
      .selen(selen), .bus_data(bus_data_i), .bus_par(bus_par_i),
      .bus_bsy(bus_bsy_i), .bus_sel(bus_sel_i), .bus_req(bus_req_i),
      .bus_ack(bus_ack_i), .dma_end(dma_end_i), .clr(clr),
      .irq(irq_o), .par_err(par_err), .busy_err(busy_err), .in_data(in_data)
   );

   assign dma_send_go  = go[0];
   assign dma_trecv_go = go[1];
   assign dma_irecv_go = go[2];
   assign arb_lost = mode[MD_ARB] && bus_sel_i && !icr[ICR_SEL];

   always_comb begin
      case (reg_addr)
         OFS_DATA: reg_rdata = bus_data_i;
         OFS_ICR:  reg_rdata = {icr[ICR_RST], mode[MD_ARB], arb_lost, icr[4:0]};
         OFS_MODE: reg_rdata = mode;
         OFS_TCR:  reg_rdata = {dma_end_i, 3'b000, tcr};
         OFS_STAT: reg_rdata = {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i,
                                bus_cd_i, bus_io_i, bus_sel_i, bus_par_i};
         OFS_BSR:  reg_rdata = {dma_end_i, drq_i, par_err, irq_o, phase_match_o,
                                busy_err, bus_atn_i, bus_ack_i};
         OFS_IN:   reg_rdata = in_data;
         default:  reg_rdata = '0;
      endcase
   end

   // R4
   oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_oe && !mode[MD_ARB]) |-> (phase_match_o && icr[ICR_DATA]));
   // R5
   tri_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      icr[ICR_TRI] |-> !(bus_data_oe || bus_bsy_o || bus_sel_o || bus_rst_o || bus_req_o));
   // R5
   tgt_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[MD_TGT] |-> !(bus_req_o || bus_msg_o || bus_cd_o || bus_io_o));
endmodule

// File: tb/test_scsi_port_regs.sv
`timescale 1ns/1ps
module test_scsi_port_regs;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, reg_wr, reg_rd, bus_par_i, bus_rst_i, bus_bsy_i, bus_sel_i;
   logic bus_req_i, bus_ack_i, bus_msg_i, bus_cd_i, bus_io_i, bus_atn_i, drq_i, dma_end_i;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata, bus_data_i, bus_data_o;
   logic bus_data_oe, bus_rst_o, bus_bsy_o, bus_sel_o, bus_atn_o, bus_ack_o, bus_req_o;
   logic bus_msg_o, bus_cd_o, bus_io_o, diff_en_o, phase_match_o, irq_o;
   logic dma_send_go, dma_trecv_go, dma_irecv_go;

   scsi_port_regs i_scsi_port_regs (.*);

   int checks = 0, errors = 0;
   logic [7:0] m_odr, m_icr, m_mode, m_tcr, rv;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      case (a)
         3'd0: m_odr = d;
         3'd1: m_icr = d;
         3'd2: m_mode = d;
         3'd3: m_tcr = {4'h0, d[3:0]};
         default: ;
      endcase
   endtask

   task automatic rreg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   function automatic logic exp_pm();
      return {bus_msg_i, bus_cd_i, bus_io_i} == m_tcr[2:0];
   endfunction

   function automatic logic [18:0] exp_drive();
      logic q = m_icr[6];
      logic t = m_mode[6] & ~q;
      return {!q & (m_mode[0] | (m_icr[0] & exp_pm())), m_odr,
              !q & m_icr[7], !q & m_icr[3], !q & m_icr[2], !q & m_icr[1], !q & m_icr[4],
              t & m_tcr[3], t & m_tcr[2], t & m_tcr[1], t & m_tcr[0], exp_pm()};
   endfunction

   function automatic logic [18:0] act_drive();
      return {bus_data_oe, bus_data_o, bus_rst_o, bus_bsy_o, bus_sel_o, bus_atn_o, bus_ack_o,
              bus_req_o, bus_msg_o, bus_cd_o, bus_io_o, phase_match_o};
   endfunction

   task automatic bus_idle();
      {bus_par_i, bus_rst_i, bus_bsy_i, bus_sel_i, bus_req_i, bus_ack_i} = '0;
      {bus_msg_i, bus_cd_i, bus_io_i, bus_atn_i, drq_i, dma_end_i} = '0;
      bus_data_i = '0;
   endtask

   task automatic handshake_byte(input logic use_ack, input logic [7:0] d, input logic p);
      @(negedge clk); if (use_ack) bus_ack_i = 1'b1; else bus_req_i = 1'b1;
      @(negedge clk); bus_data_i = d; bus_par_i = p;
      if (use_ack) bus_ack_i = 1'b0; else bus_req_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5C51));
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      bus_idle();
      m_odr = '0; m_icr = '0; m_mode = '0; m_tcr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1 outputs", {bus_data_oe, bus_rst_o, bus_bsy_o, bus_sel_o, bus_atn_o, bus_ack_o,
                         bus_req_o, bus_msg_o, bus_cd_o, bus_io_o, irq_o}, '0);
      rreg(3'd1, rv); chk("R1 icr", rv, 8'h00);
      rreg(3'd2, rv); chk("R1 mode", rv, 8'h00);
      rreg(3'd3, rv); chk("R1 tcr", rv, 8'h00);

      // R2 live views
      @(negedge clk); bus_data_i = 8'hA5; bus_rst_i = 1; bus_req_i = 1; bus_cd_i = 1;
      bus_par_i = 1;
      rreg(3'd0, rv); chk("R2 data view", rv, 8'hA5);
      rreg(3'd4, rv); chk("R2 status view", rv, 8'b1010_1001);
      @(negedge clk); bus_idle();

      // random mix: R3 R4 R5 R2
      for (int i = 0; i < 200; i++) begin
         logic [2:0] ra;
         @(negedge clk);
         {bus_msg_i, bus_cd_i, bus_io_i, bus_sel_i, bus_atn_i, bus_ack_i, drq_i} = 7'($urandom);
         dma_end_i = 1'b0;
         bus_data_i = 8'($urandom);
         ra = 3'($urandom_range(0, 3));
         wreg(ra, 8'($urandom));
         #1;
         chk("R4 R5 R3 drive", act_drive(), exp_drive());
         chk("R5 diff", diff_en_o, m_icr[5]);
         case (i % 4)
            0: begin rreg(3'd1, rv);
                  chk("R2 icr read", rv, {m_icr[7], m_mode[0],
                      m_mode[0] & bus_sel_i & ~m_icr[2], m_icr[4:0]}); end
            1: begin rreg(3'd2, rv); chk("R2 mode read", rv, m_mode); end
            2: begin rreg(3'd3, rv); chk("R2 tcr read", rv, {4'h0, m_tcr[3:0]}); end
            default: begin rreg(3'd5, rv);
                  chk("R3 bsr bits", {rv[7:6], rv[3], rv[1:0]},
                      {1'b0, drq_i, exp_pm(), bus_atn_i, bus_ack_i}); end
         endcase
      end

      // directed phase encodings (R3): message in 111 and data out 000
      wreg(3'd3, 8'h07); wreg(3'd2, 8'h00); wreg(3'd1, 8'h01);
      @(negedge clk); {bus_msg_i, bus_cd_i, bus_io_i} = 3'b111; #1;
      chk("R3 msg in match", phase_match_o, 1'b1);
      chk("R4 data on match", bus_data_oe, 1'b1);
      @(negedge clk); {bus_msg_i, bus_cd_i, bus_io_i} = 3'b110; #1;
      chk("R4 data off mismatch", bus_data_oe, 1'b0);
      wreg(3'd1, 8'h41); wreg(3'd2, 8'h01); #1;
      chk("R5 tri overrides arbitration", bus_data_oe, 1'b0);

      wreg(3'd1, 8'h00); wreg(3'd2, 8'h00); wreg(3'd3, 8'h00);
      @(negedge clk); bus_idle();
      rreg(3'd7, rv);

      // R6 strobes
      wreg(3'd1, 8'h9A);
      for (int k = 5; k < 8; k++) begin
         @(negedge clk); reg_addr = 3'(k); reg_wdata = 8'hFF; reg_wr = 1'b1; #1;
         chk("R6 strobe", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b100 >> (k - 5));
         @(negedge clk); reg_wr = 1'b0; #1;
         chk("R6 strobe end", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b000);
      end
      rreg(3'd1, rv); chk("R6 icr untouched", rv, {m_icr[7], 1'b0, 1'b0, m_icr[4:0]});
      rreg(3'd2, rv); chk("R6 mode untouched", rv, 8'h00);
      wreg(3'd1, 8'h00);

      // R7 selection
      wreg(3'd4, 8'h20);
      @(negedge clk); bus_sel_i = 1; bus_data_i = 8'h10;
      @(negedge clk); #1 chk("R7 masked id no irq", irq_o, 1'b0);
      bus_data_i = 8'h20;
      @(negedge clk); #1 chk("R7 selected irq", irq_o, 1'b1);
      bus_sel_i = 0; bus_data_i = 0;
      rreg(3'd5, rv); chk("R7 irq mirror", rv[4], 1'b1);
      rreg(3'd7, rv); #1 chk("R11 irq cleared", irq_o, 1'b0);

      // R8 R9 parity and latch
      wreg(3'd2, 8'h30);
      handshake_byte(1'b0, 8'h5A, 1'b1);
      rreg(3'd6, rv); chk("R8 latched byte", rv, 8'h5A);
      rreg(3'd5, rv); chk("R9 good parity", {rv[5], rv[4]}, 2'b00);
      handshake_byte(1'b0, 8'h3C, 1'b0);
      rreg(3'd5, rv); chk("R9 bad parity flags", {rv[5], rv[4]}, 2'b11);
      rreg(3'd5, rv); chk("R9 parity sticky", rv[5], 1'b1);
      rreg(3'd7, rv);
      rreg(3'd5, rv); chk("R11 parity cleared", {rv[5], rv[4]}, 2'b00);
      wreg(3'd2, 8'h40);
      handshake_byte(1'b1, 8'h81, 1'b1);
      rreg(3'd6, rv); chk("R8 target ack latch", rv, 8'h81);
      @(negedge clk); bus_idle();

      // R10 busy
      wreg(3'd2, 8'h00);
      @(negedge clk); bus_bsy_i = 1; @(negedge clk); bus_bsy_i = 0;
      @(negedge clk); #1 chk("R10 unmonitored drop", irq_o, 1'b0);
      wreg(3'd2, 8'h04);
      @(negedge clk); bus_bsy_i = 1; @(negedge clk); bus_bsy_i = 0;
      @(negedge clk); #1 chk("R10 monitored drop irq", irq_o, 1'b1);
      rreg(3'd5, rv); chk("R10 busy error bit", rv[2], 1'b1);
      rreg(3'd7, rv);
      rreg(3'd5, rv); chk("R11 busy cleared", {rv[4], rv[2]}, 2'b00);

      // R12 end of DMA
      wreg(3'd2, 8'h08);
      @(negedge clk); dma_end_i = 1;
      @(negedge clk); #1 chk("R12 eop irq", irq_o, 1'b1);
      rreg(3'd3, rv); chk("R2 end flag in tcr view", rv[7], 1'b1);
      rreg(3'd7, rv); #1 chk("R11 eop cleared", irq_o, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule